// File: doc/BRIEF.md
# Programmable Raster Sync Timing Generator

This block produces the timing for a parallel RGB display panel from a single pixel clock. A horizontal counter steps through each line and a vertical counter steps through each frame. Both counters are set entirely by runtime inputs, so one piece of hardware can drive panels with different timings. For each axis, four values define the timing: the total length, the count where the sync pulse goes low, the count where it goes high again, and the count where active video begins.

A line starts at count zero, which is the first clock of the front porch. Active video therefore sits at the end of the line, starting at the programmed active offset, which equals front porch plus sync width plus back porch. Frames follow the same scheme, counted in lines. The block drives active-low horizontal and vertical sync, a data-enable strobe, and the x/y position of the current pixel within the active area.

The block holds a private copy of the timing inputs. It takes a new copy only during reset and at the clock that ends a frame, so a change made in the middle of a frame never tears the picture.

Top module: `disp_sync_gen`

## Requirements
- R1: The horizontal count starts at 0 on the first clock after reset, steps by one each clock, and returns to 0 after reaching `h_total`−1. A line therefore lasts `h_total` clocks and begins at the start of the front porch.
- R2: `hsync_n` is 0 exactly while the horizontal count c satisfies `h_sync_on` ≤ c < `h_sync_off`. The pulse is `h_sync_off`−`h_sync_on` clocks wide, and equal values give no pulse.
- R3: The vertical count steps by one only on the clock where the horizontal count wraps, and it returns to 0 after line `v_total`−1. The output pattern repeats every `h_total`×`v_total` clocks.
- R4: `vsync_n` is 0 exactly while the vertical count v satisfies `v_sync_on` ≤ v < `v_sync_off`. During those lines it stays low for every clock of the line.
- R5: `de` is 1 exactly when the horizontal count is at least `h_act_at` and the vertical count is at least `v_act_at`.
- R6: While `de` is 1, `px_x` equals the horizontal count minus `h_act_at` and `px_y` equals the vertical count minus `v_act_at`. Both are 0 at the first active pixel.
- R7: While `de` is 0, `px_x` and `px_y` are both 0.
- R8: The timing inputs are sampled only at the clock where the last pixel of a frame wraps. A change in mid-frame has no effect on the rest of that frame and governs the whole of the next frame.
- R9: While `rst_n` is 0 at a clock edge, both counters clear and the timing inputs are copied. On the first clock after reset, the outputs reflect count (0,0) under the inputs held during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| h_total | input | 12 | Clocks per line |
| h_sync_on | input | 12 | Horizontal count where sync goes low (front porch length) |
| h_sync_off | input | 12 | Horizontal count where sync returns high |
| h_act_at | input | 12 | Horizontal count of the first active pixel |
| v_total | input | 12 | Lines per frame |
| v_sync_on | input | 12 | Line where vertical sync goes low |
| v_sync_off | input | 12 | Line where vertical sync returns high |
| v_act_at | input | 12 | First active line |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| de | output | 1 | Data enable, high on active pixels |
| px_x | output | 12 | Active-area column, 0 outside active video |
| px_y | output | 12 | Active-area row, 0 outside active video |

## Verification
The properties assume consistent timing on each axis: the total is at least 2, sync-on does not exceed sync-off, sync-off does not exceed the total, and the active offset is below the total. The counter-step properties also assume that inputs are only ever taken at a frame boundary. Every timing set in the stimulus table meets these bounds, including the edge settings with zero-length porch, zero-width pulse and a single active pixel. The mid-frame change test switches between two valid sets, so both the old and the new frame stay inside the bounds.

// File: rtl/disp_sync_pkg.sv
// Package: shared width and per-axis timing record for the raster sync generator.
// Assumes every counter and timing value fits in DSG_CW bits.
package disp_sync_pkg;
    parameter int unsigned DSG_CW = 12;

    // One axis of timing: all values are in that axis' counting unit
    typedef struct packed {
        logic [DSG_CW-1:0] total;
        logic [DSG_CW-1:0] sync_on;
        logic [DSG_CW-1:0] sync_off;
        logic [DSG_CW-1:0] act_at;
    } axis_tmg_t;
endpackage

// File: rtl/disp_sync_shadow.sv
// Module: holds the timing set in force for the current frame.
// Loads the live inputs while reset is held and on the frame-end strobe;
// holds otherwise. Assumes load is a single-clock pulse.
module disp_sync_shadow
    import disp_sync_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load,
    input  axis_tmg_t live_h,
    input  axis_tmg_t live_v,
    output axis_tmg_t cur_h,
    output axis_tmg_t cur_v
);
    // Capture the live timing at reset and at frame end only
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            cur_h <= live_h;
            cur_v <= live_v;
        end
    end
endmodule

// File: rtl/disp_sync_axis.sv
// Module: one timing axis - a wrapping counter plus sync/active decode.
// Counts when step is high; wrap marks the step that returns to 0.
// Assumes total >= 2, sync_on <= sync_off <= total, act_at < total.
module disp_sync_axis
    import disp_sync_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  axis_tmg_t         tmg,
    output logic [DSG_CW-1:0] cnt,
    output logic              wrap,
    output logic              sync_n,
    output logic              act,
    output logic [DSG_CW-1:0] pos
);
    logic at_last;

    // Detect the final count of the period (>= guards a shrunk total)
    always_comb at_last = (cnt >= tmg.total - DSG_CW'(1));

    // Advance or wrap the count on each step
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (step)
            cnt <= at_last ? '0 : cnt + DSG_CW'(1);
    end

    // Decode wrap strobe, sync window, active window and active position
    always_comb begin
        wrap   = step && at_last;
        sync_n = !((cnt >= tmg.sync_on) && (cnt < tmg.sync_off));
        act    = (cnt >= tmg.act_at);
        pos    = cnt - tmg.act_at;
    end
endmodule

// File: rtl/disp_sync_gen.sv
// Module: programmable raster sync generator top.
// Line and frame start at the front porch; active video begins at the
// programmed offsets. Timing inputs are taken at reset and frame end.
module disp_sync_gen
    import disp_sync_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DSG_CW-1:0] h_total,
    input  logic [DSG_CW-1:0] h_sync_on,
    input  logic [DSG_CW-1:0] h_sync_off,
    input  logic [DSG_CW-1:0] h_act_at,
    input  logic [DSG_CW-1:0] v_total,
    input  logic [DSG_CW-1:0] v_sync_on,
    input  logic [DSG_CW-1:0] v_sync_off,
    input  logic [DSG_CW-1:0] v_act_at,
    output logic              hsync_n,
    output logic              vsync_n,
    output logic              de,
    output logic [DSG_CW-1:0] px_x,
    output logic [DSG_CW-1:0] px_y
);
    axis_tmg_t         live_h, live_v, sh_h, sh_v;
    logic [DSG_CW-1:0] hc, vc, hpos, vpos;
    logic              h_wrap, v_wrap, h_act, v_act, frame_end;

    // Pack the live inputs into per-axis records
    always_comb begin
        live_h = '{total: h_total, sync_on: h_sync_on, sync_off: h_sync_off, act_at: h_act_at};
        live_v = '{total: v_total, sync_on: v_sync_on, sync_off: v_sync_off, act_at: v_act_at};
    end

    // Frame ends on the clock where both axes wrap together
    always_comb frame_end = h_wrap && v_wrap;

    disp_sync_shadow u_shadow (
        .clk(clk), .rst_n(rst_n), .load(frame_end),
        .live_h(live_h), .live_v(live_v), .cur_h(sh_h), .cur_v(sh_v)
    );

    disp_sync_axis u_hax (
        .clk(clk), .rst_n(rst_n), .step(1'b1), .tmg(sh_h),
        .cnt(hc), .wrap(h_wrap), .sync_n(hsync_n), .act(h_act), .pos(hpos)
    );

    disp_sync_axis u_vax (
        .clk(clk), .rst_n(rst_n), .step(h_wrap), .tmg(sh_v),
        .cnt(vc), .wrap(v_wrap), .sync_n(vsync_n), .act(v_act), .pos(vpos)
    );

    // Combine the axes into data enable and gated coordinates
    always_comb begin
        de   = h_act && v_act;
        px_x = de ? hpos : '0;
        px_y = de ? vpos : '0;
    end
endmodule

// File: rtl/disp_sync_chk.sv
// Checker: temporal properties of the sync generator, bound to its top.
// Assumes consistent timing sets, loaded only at frame boundaries.
module disp_sync_chk
    import disp_sync_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              hsync_n,
    input logic              de,
    input logic [DSG_CW-1:0] px_x,
    input logic [DSG_CW-1:0] px_y,
    input logic [DSG_CW-1:0] hc,
    input logic [DSG_CW-1:0] vc,
    input axis_tmg_t         sh_h,
    input axis_tmg_t         sh_v
);
    // R1: a nonzero count is always one more than the previous count
    p_h_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (hc != '0) |-> (hc == $past(hc) + DSG_CW'(1)));

    // R1: the last count of a line is followed by zero
    p_h_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (hc == sh_h.total - DSG_CW'(1)) |=> (hc == '0));

    // R2: horizontal sync falls only at the sync-on count
    p_hs_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hsync_n) |-> (hc == sh_h.sync_on));

    // R3: the line count holds except at the start of a line
    p_v_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hc != '0) |-> $stable(vc));

    // R5: data enable never appears above the first active line
    p_de_rows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> (vc >= sh_v.act_at));

    // R6: within a line the column advances by one per clock
    p_x_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (de && px_x != '0) |-> ($past(de) && px_x == $past(px_x) + DSG_CW'(1)));

    // R7: coordinates rest at zero outside active video
    p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !de |-> (px_x == '0 && px_y == '0));

    // R8: the timing copy only changes on the first clock of a frame
    p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(hc == '0 && vc == '0) |-> ($stable(sh_h) && $stable(sh_v)));
endmodule

bind disp_sync_gen disp_sync_chk u_chk (
    .clk(clk), .rst_n(rst_n), .hsync_n(hsync_n), .de(de),
    .px_x(px_x), .px_y(px_y), .hc(hc), .vc(vc), .sh_h(sh_h), .sh_v(sh_v)
);

// File: tb/disp_sync_gen_test.sv
// Bench: table-driven frame measurements, then reset and mid-frame change tests.
module disp_sync_gen_test;
    import disp_sync_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [DSG_CW-1:0] h_total, h_sync_on, h_sync_off, h_act_at;
    logic [DSG_CW-1:0] v_total, v_sync_on, v_sync_off, v_act_at;
    logic hsync_n, vsync_n, de;
    logic [DSG_CW-1:0] px_x, px_y;

    always #2.5 clk = ~clk;

    disp_sync_gen uut (
        .clk(clk), .rst_n(rst_n),
        .h_total(h_total), .h_sync_on(h_sync_on), .h_sync_off(h_sync_off), .h_act_at(h_act_at),
        .v_total(v_total), .v_sync_on(v_sync_on), .v_sync_off(v_sync_off), .v_act_at(v_act_at),
        .hsync_n(hsync_n), .vsync_n(vsync_n), .de(de), .px_x(px_x), .px_y(px_y)
    );

    // cfg: ht hs0 hs1 hoff vt vs0 vs1 voff | exp: hlow vlow de first_de xmax ymax f1 f2 vfall
    localparam int NV = 4;
    localparam int VEC [NV][17] = '{
        '{10, 2, 3,  5, 6, 1, 3, 4,  6, 20, 10, 45, 4, 1,  2, 12, 10},
        '{16, 3, 7, 10, 5, 0, 1, 2, 20, 16, 18, 42, 5, 2,  3, 19,  0},
        '{ 8, 0, 2,  0, 4, 2, 4, 0,  8, 16, 32,  0, 7, 3,  0,  8, 16},
        '{12, 5, 5, 11, 3, 1, 2, 2,  0, 12,  1, 35, 0, 0, -1, -1, 12}
    };

    int n_run = 0, n_fail = 0;
    bit finished = 1'b0;
    int m_hlow, m_vlow, m_de, m_fde, m_xmax, m_ymax, m_f1, m_f2, m_vf, m_idle, m_x0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic set_cfg(input int v);
        h_total = DSG_CW'(VEC[v][0]); h_sync_on = DSG_CW'(VEC[v][1]);
        h_sync_off = DSG_CW'(VEC[v][2]); h_act_at = DSG_CW'(VEC[v][3]);
        v_total = DSG_CW'(VEC[v][4]); v_sync_on = DSG_CW'(VEC[v][5]);
        v_sync_off = DSG_CW'(VEC[v][6]); v_act_at = DSG_CW'(VEC[v][7]);
    endtask

    // Reset with the current inputs; returns at the negedge of cycle 0
    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
    endtask

    // Sample n cycles at negedges, positions relative to the first sample
    task automatic measure(input int n);
        bit prev_hs = 1'b1, prev_vs = 1'b1, first = 1'b1;
        m_hlow = 0; m_vlow = 0; m_de = 0; m_fde = -1; m_xmax = 0; m_ymax = 0;
        m_f1 = -1; m_f2 = -1; m_vf = -1; m_idle = 0; m_x0 = 0;
        for (int i = 0; i < n; i++) begin
            if (!hsync_n) m_hlow++;
            if (!vsync_n) m_vlow++;
            if (prev_hs && !hsync_n) begin
                if (m_f1 < 0) m_f1 = i; else if (m_f2 < 0) m_f2 = i;
            end
            if (prev_vs && !vsync_n && m_vf < 0) m_vf = i;
            if (de) begin
                m_de++;
                if (first) begin
                    m_fde = i; first = 1'b0;
                    m_x0 = int'(px_x) + int'(px_y);
                end
                if (int'(px_x) > m_xmax) m_xmax = int'(px_x);
                if (int'(px_y) > m_ymax) m_ymax = int'(px_y);
            end else if (px_x != '0 || px_y != '0) begin
                m_idle++;
            end
            prev_hs = hsync_n; prev_vs = vsync_n;
            @(negedge clk);
        end
    endtask

    initial begin
        set_cfg(0);
        // R9: reset state at cycle 0 with the first table entry held in reset
        do_reset();
        chk("R9", "hsync_n after reset", int'(hsync_n), 1);
        chk("R9", "vsync_n after reset", int'(vsync_n), 1);
        chk("R9", "de after reset", int'(de), 0);
        chk("R9", "px after reset", int'(px_x) + int'(px_y), 0);

        // Table walk: one frame measured, then the following frame
        for (int v = 0; v < NV; v++) begin
            int frame;
            int f_hlow, f_de, f_fde;
            frame = VEC[v][0] * VEC[v][4];
            set_cfg(v);
            do_reset();
            measure(frame);
            chk("R2", "hsync low clocks per frame", m_hlow, VEC[v][8]);
            chk("R4", "vsync low clocks per frame", m_vlow, VEC[v][9]);
            chk("R5", "de clocks per frame", m_de, VEC[v][10]);
            chk("R5", "first de cycle", m_fde, VEC[v][11]);
            chk("R6", "max px_x", m_xmax, VEC[v][12]);
            chk("R6", "max px_y", m_ymax, VEC[v][13]);
            chk("R6", "coordinates at first pixel", m_x0, 0);
            chk("R2", "first hsync fall", m_f1, VEC[v][14]);
            chk("R1", "second hsync fall", m_f2, VEC[v][15]);
            chk("R4", "first vsync fall", m_vf, VEC[v][16]);
            chk("R7", "nonzero px while de low", m_idle, 0);
            f_hlow = m_hlow; f_de = m_de; f_fde = m_fde;
            measure(frame);
            chk("R3", "next frame hsync low clocks", m_hlow, f_hlow);
            chk("R3", "next frame de clocks", m_de, f_de);
            chk("R3", "next frame first de", m_fde, f_fde);
        end

        // R8: switch to entry 1 twenty clocks into an entry-0 frame
        begin
            int ha, da;
            set_cfg(0);
            do_reset();
            measure(20);
            ha = m_hlow; da = m_de;
            set_cfg(1);
            measure(40);
            chk("R8", "old frame hsync low clocks", ha + m_hlow, VEC[0][8]);
            chk("R8", "old frame de clocks", da + m_de, VEC[0][10]);
            measure(80);
            chk("R8", "new frame hsync low clocks", m_hlow, VEC[1][8]);
            chk("R8", "new frame first de", m_fde, VEC[1][11]);
            chk("R8", "new frame vsync low clocks", m_vlow, VEC[1][9]);
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule